// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address in a 1 MB space. It keeps four segment registers (code, data, extra, stack) and four offset registers (instruction pointer, stack pointer, source index, destination index). Each register is written synchronously through an enable-per-register load port.

A 3-bit access type picks which segment and which offset to combine. One clock later the block presents three results: the physical address, the lowest address of the chosen 64 KB segment, and its highest address. All arithmetic wraps modulo 2^20. Access codes that name no access leave the outputs unchanged and drop the valid flag.

The output stage is a two-state machine. `OUT_IDLE` means no result is presented, and `OUT_VALID` means a result is presented. Every cycle it takes the transition `take_request` to `OUT_VALID` when the access code is 0 to 5. Otherwise it takes `skip_request` to `OUT_IDLE`. Reset forces `OUT_IDLE`.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to 0000h, clears `pa_out`, `seg_lo` and `seg_hi`, and deasserts `pa_valid`.
- R2: On a clock edge, bit i of `seg_wr_en` loads `seg_wr_data` into segment register i. The indices are 0 = code, 1 = data, 2 = extra, 3 = stack.
- R3: On a clock edge, bit i of `ofs_wr_en` loads `ofs_wr_data` into offset register i. The indices are 0 = instruction pointer, 1 = stack pointer, 2 = source index, 3 = destination index.
- R4: `acc_type` selects the pair as follows:
  - 0: code segment : instruction pointer
  - 1: stack segment : stack pointer
  - 2: data segment : source index
  - 3: data segment : destination index
  - 4: extra segment : source index
  - 5: extra segment : destination index
- R5: `pa_out` = segment × 10h + offset, modulo 2^20. Examples: 2000:45AB gives 245ABh, B000:1234 gives B1234h, 0000:FFFC gives 0FFFCh, and FFFF:0010 gives 00000h.
- R6: `seg_lo` = segment × 10h, which always has a low hex digit of zero. `seg_hi` = segment × 10h + FFFFh, modulo 2^20. For segment 7FA2 the bounds are 7FA20h and 8FA1Fh.
- R7: A request with code 0–5 produces its results and `pa_valid` = 1 exactly one clock edge later.
- R8: Codes 6 and 7 leave `pa_out`, `seg_lo` and `seg_hi` unchanged and give `pa_valid` = 0 after the edge.
- R9: When a register load and a request fall in the same cycle, the request uses the register value held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 4 | Per-segment-register load enables |
| seg_wr_data | input | 16 | Segment load value |
| ofs_wr_en | input | 4 | Per-offset-register load enables |
| ofs_wr_data | input | 16 | Offset load value |
| acc_type | input | 3 | Access type code |
| pa_out | output | 20 | Physical address |
| seg_lo | output | 20 | Lowest address of selected segment |
| seg_hi | output | 20 | Highest address of selected segment |
| pa_valid | output | 1 | Results valid |

## Verification
Every result is due one clock edge after its stimulus. This covers register loads, the address, the bounds, `pa_valid`, and the held values for codes 6 and 7.

The bench drives inputs on the falling edge and checks the outputs on the following falling edge. That way exactly one rising edge separates stimulus from check. Expected values come from the register model as it stood before that edge, and any loads are applied to the model only afterwards. This ordering is what lets the bench test R9.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W   = 16;
    localparam int OFS_W   = 16;
    localparam int PA_W    = 20;
    localparam int NUM_SEG = 4;
    localparam int NUM_OFS = 4;

    localparam int SEG_CODE  = 0;
    localparam int SEG_DATA  = 1;
    localparam int SEG_EXTRA = 2;
    localparam int SEG_STACK = 3;

    localparam int OFS_IP = 0;
    localparam int OFS_SP = 1;
    localparam int OFS_SI = 2;
    localparam int OFS_DI = 3;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_STACK = 3'd1,
        ACC_DSRC  = 3'd2,
        ACC_DDST  = 3'd3,
        ACC_XSRC  = 3'd4,
        ACC_XDST  = 3'd5,
        ACC_NONE6 = 3'd6,
        ACC_NONE7 = 3'd7
    } acc_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          wr_en,
    input  logic [W-1:0]          wr_data,
    output logic [N-1:0][W-1:0]   q
);
    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (wr_en[i])
                q[i] <= wr_data;
        end

        // R2 / R3: an enabled entry holds the written value after the edge
        assert_load_R2_R3: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |=> (q[i] == $past(wr_data)));

        // R2 / R3: a disabled entry keeps its value
        assert_keep_R2_R3: assert property (@(posedge clk) disable iff (rst)
            !wr_en[i] |=> $stable(q[i]));
    end
endmodule

// File: rtl/pair_select.sv
module pair_select
    import seg_addr_pkg::*;
#(
    parameter int SW = 16,
    parameter int OW = 16,
    parameter int NS = 4,
    parameter int NO = 4
) (
    input  logic [NS-1:0][SW-1:0] seg_q,
    input  logic [NO-1:0][OW-1:0] ofs_q,
    input  logic [2:0]            acc_type,
    output logic [SW-1:0]         sel_seg,
    output logic [OW-1:0]         sel_ofs,
    output logic                  req
);
    acc_e acc;
    assign acc = acc_e'(acc_type);

    always_comb begin
        sel_seg = '0;
        sel_ofs = '0;
        req     = 1'b1;
        unique case (acc)
            ACC_FETCH: begin sel_seg = seg_q[SEG_CODE];  sel_ofs = ofs_q[OFS_IP]; end
            ACC_STACK: begin sel_seg = seg_q[SEG_STACK]; sel_ofs = ofs_q[OFS_SP]; end
            ACC_DSRC:  begin sel_seg = seg_q[SEG_DATA];  sel_ofs = ofs_q[OFS_SI]; end
            ACC_DDST:  begin sel_seg = seg_q[SEG_DATA];  sel_ofs = ofs_q[OFS_DI]; end
            ACC_XSRC:  begin sel_seg = seg_q[SEG_EXTRA]; sel_ofs = ofs_q[OFS_SI]; end
            ACC_XDST:  begin sel_seg = seg_q[SEG_EXTRA]; sel_ofs = ofs_q[OFS_DI]; end
            default:   req = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_calc.sv
module addr_calc #(
    parameter int SW = 16,
    parameter int OW = 16,
    parameter int PW = 20
) (
    input  logic [SW-1:0] seg,
    input  logic [OW-1:0] ofs,
    output logic [PW-1:0] pa,
    output logic [PW-1:0] lo,
    output logic [PW-1:0] hi
);
    localparam int SHIFT = PW - SW;

    logic [PW-1:0] base;
    logic [PW-1:0] ofs_ext;
    logic [PW-1:0] ofs_max;

    assign base    = {seg, {SHIFT{1'b0}}};
    assign ofs_ext = {{(PW-OW){1'b0}}, ofs};
    assign ofs_max = {{(PW-OW){1'b0}}, {OW{1'b1}}};

    assign pa = base + ofs_ext;
    assign lo = base;
    assign hi = base + ofs_max;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFS_W,
    parameter int PW = PA_W,
    parameter int NS = NUM_SEG,
    parameter int NO = NUM_OFS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] seg_wr_en,
    input  logic [SW-1:0] seg_wr_data,
    input  logic [NO-1:0] ofs_wr_en,
    input  logic [OW-1:0] ofs_wr_data,
    input  logic [2:0]    acc_type,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] seg_lo,
    output logic [PW-1:0] seg_hi,
    output logic          pa_valid
);
    logic [NS-1:0][SW-1:0] seg_q;
    logic [NO-1:0][OW-1:0] ofs_q;
    logic [SW-1:0]         sel_seg;
    logic [OW-1:0]         sel_ofs;
    logic                  req;
    logic [PW-1:0]         pa_d, lo_d, hi_d;
    out_state_e            state_q, state_d;

    seg_bank #(.W(SW), .N(NS)) u_segs (
        .clk(clk), .rst(rst), .wr_en(seg_wr_en), .wr_data(seg_wr_data), .q(seg_q));

    seg_bank #(.W(OW), .N(NO)) u_ofss (
        .clk(clk), .rst(rst), .wr_en(ofs_wr_en), .wr_data(ofs_wr_data), .q(ofs_q));

    pair_select #(.SW(SW), .OW(OW), .NS(NS), .NO(NO)) u_sel (
        .seg_q(seg_q), .ofs_q(ofs_q), .acc_type(acc_type),
        .sel_seg(sel_seg), .sel_ofs(sel_ofs), .req(req));

    addr_calc #(.SW(SW), .OW(OW), .PW(PW)) u_calc (
        .seg(sel_seg), .ofs(sel_ofs), .pa(pa_d), .lo(lo_d), .hi(hi_d));

    // transitions: take_request -> OUT_VALID, skip_request -> OUT_IDLE
    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = req ? OUT_VALID : OUT_IDLE;
            OUT_VALID: state_d = req ? OUT_VALID : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= OUT_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_out <= '0;
            seg_lo <= '0;
            seg_hi <= '0;
        end else if (state_d == OUT_VALID) begin
            pa_out <= pa_d;
            seg_lo <= lo_d;
            seg_hi <= hi_d;
        end
    end

    assign pa_valid = (state_q == OUT_VALID);

    assert_valid_next_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_type <= 3'd5) |=> pa_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_type >= 3'd6) |=> (!pa_valid && $stable(pa_out) && $stable(seg_lo) && $stable(seg_hi)));

    assert_base_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        pa_valid |-> (seg_lo[3:0] == 4'h0));

    assert_span_R6: assert property (@(posedge clk) disable iff (rst)
        pa_valid |-> (PW'(seg_hi - seg_lo) == PW'({OW{1'b1}})));

    assert_in_segment_R5: assert property (@(posedge clk) disable iff (rst)
        pa_valid |-> (PW'(pa_out - seg_lo) <= PW'({OW{1'b1}})));
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  seg_wr_en;
    logic [15:0] seg_wr_data;
    logic [3:0]  ofs_wr_en;
    logic [15:0] ofs_wr_data;
    logic [2:0]  acc_type;
    logic [19:0] pa_out, seg_lo, seg_hi;
    logic        pa_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] m_seg [4];
    logic [15:0] m_ofs [4];
    logic [19:0] h_pa, h_lo, h_hi;

    always #2 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst(rst),
        .seg_wr_en(seg_wr_en), .seg_wr_data(seg_wr_data),
        .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data),
        .acc_type(acc_type),
        .pa_out(pa_out), .seg_lo(seg_lo), .seg_hi(seg_hi), .pa_valid(pa_valid));

    function automatic logic [19:0] ref_addr(logic [15:0] s, logic [15:0] o);
        logic [20:0] sum;
        sum = s * 21'h10 + o;
        return sum[19:0];
    endfunction

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] se, input logic [15:0] sd,
                        input logic [3:0] oe, input logic [15:0] od,
                        input logic [2:0] at, input string tag);
        logic [15:0] s, o;
        logic        ev;
        ev = 1'b1;
        s  = '0;
        o  = '0;
        case (at)
            3'd0: begin s = m_seg[0]; o = m_ofs[0]; end
            3'd1: begin s = m_seg[3]; o = m_ofs[1]; end
            3'd2: begin s = m_seg[1]; o = m_ofs[2]; end
            3'd3: begin s = m_seg[1]; o = m_ofs[3]; end
            3'd4: begin s = m_seg[2]; o = m_ofs[2]; end
            3'd5: begin s = m_seg[2]; o = m_ofs[3]; end
            default: ev = 1'b0;
        endcase
        if (ev) begin
            h_pa = ref_addr(s, o);
            h_lo = ref_addr(s, 16'h0000);
            h_hi = ref_addr(s, 16'hFFFF);
        end
        seg_wr_en = se; seg_wr_data = sd;
        ofs_wr_en = oe; ofs_wr_data = od;
        acc_type  = at;
        @(negedge clk);
        chk({tag, " pa"}, pa_out, h_pa);
        chk("R6 lo", seg_lo, h_lo);
        chk("R6 hi", seg_hi, h_hi);
        chk(ev ? "R7 valid" : "R8 valid", {19'd0, pa_valid}, {19'd0, ev});
        for (int i = 0; i < 4; i++) begin
            if (se[i]) m_seg[i] = sd;
            if (oe[i]) m_ofs[i] = od;
        end
        seg_wr_en = '0;
        ofs_wr_en = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        seg_wr_en = '0; seg_wr_data = '0;
        ofs_wr_en = '0; ofs_wr_data = '0;
        acc_type = 3'd7;
        for (int i = 0; i < 4; i++) begin
            m_seg[i] = '0;
            m_ofs[i] = '0;
        end
        h_pa = '0; h_lo = '0; h_hi = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {19'd0, pa_valid}, 20'd0);
        chk("R1 pa", pa_out, 20'd0);
        rst = 1'b0;

        // R1: registers cleared, so every pair reads zero
        for (int t = 0; t < 6; t++) step(4'h0, 16'h0, 4'h0, 16'h0, 3'(t), "R1");

        // R2, R3: load each register with a distinct value
        step(4'b0001, 16'h0000, 4'b0001, 16'hFFFC, 3'd7, "R8");
        step(4'b0010, 16'h2000, 4'b0100, 16'h45AB, 3'd7, "R8");
        step(4'b0100, 16'h7FA2, 4'b1000, 16'h438E, 3'd6, "R8");
        step(4'b1000, 16'hB000, 4'b0010, 16'h1234, 3'd7, "R8");

        // R4: each access code selects its own pair
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd0, "R4 R5 code:ip 0FFFC");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd2, "R4 R5 data:si 245AB");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd1, "R4 R5 stack:sp B1234");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd5, "R4 R6 extra:di 83DAE");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd3, "R4 data:di");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd4, "R4 extra:si");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd6, "R8 hold");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd7, "R8 hold");

        // R5: wrap at 2^20
        step(4'b0010, 16'hFFFF, 4'b0100, 16'h0010, 3'd7, "R8");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd2, "R5 wrap");

        // R9: same-cycle load and request sees old value
        step(4'b0010, 16'h1111, 4'b0100, 16'h2222, 3'd2, "R9 old");
        step(4'h0, 16'h0, 4'h0, 16'h0, 3'd2, "R9 new");

        // R2, R3: multi-bit enables write all selected registers
        step(4'b1111, 16'hABCD, 4'b1111, 16'h0F0F, 3'd0, "R2 R3");
        for (int t = 0; t < 6; t++) step(4'h0, 16'h0, 4'h0, 16'h0, 3'(t), "R2 R3 all");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [3:0] se, oe;
            se = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            oe = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            step(se, 16'($urandom), oe, 16'($urandom), 3'($urandom), "R5 rnd");
        end

        // R1: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 valid", {19'd0, pa_valid}, 20'd0);
        chk("R1 pa", pa_out, 20'd0);
        for (int i = 0; i < 4; i++) begin
            m_seg[i] = '0;
            m_ofs[i] = '0;
        end
        h_pa = '0; h_lo = '0; h_hi = '0;
        for (int t = 0; t < 6; t++) step(4'h0, 16'h0, 4'h0, 16'h0, 3'(t), "R1 cleared");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule